// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a synchronous host and a 32-bit-wide array of EDO DRAM devices. The host presents one request at a time through a valid/ready handshake: a 24-bit word address, a write flag, 32 bits of write data and four byte enables. The controller splits the address into a 12-bit row and a 12-bit column and places them one after the other on a shared address bus. It lowers the row strobe, then the column strobes, and finally precharges the array. A read returns one data word with a single-cycle valid pulse.

All timing between strobe edges is set by parameters counted in clock cycles. The column phase and the precharge phase are derived from those parameters, so the row-active time, the access times and the full random cycle time are all met at the same time. Writes are early writes only. Write enable and the data drivers are already active when the column strobes fall, so the controller never drives the data bus during a read. Refresh is arbitrated with a separate scheduler through a request/grant pair. A grant is given only between accesses, and it blocks the host while it is held.

Top module: `edoAccessCtrl`

## Requirements
- R1: While reset is held and in the first cycle after it, memRasN is 1, memCasN is 4'hF, memWeN is 1, memDqOe is 0, rdValid is 0, refGrant is 0 and reqReady is 1.
- R2: During an access, memAddr carries reqAddr[23:12] (the row) while memRasN is low and no column strobe is low. It carries reqAddr[11:0] (the column) while any column strobe is low.
- R3: With the default parameters, memRasN stays low for exactly 6 cycles per access. The column strobes fall in the third cycle of row-strobe activity, that is 2 cycles after memRasN falls. No column strobe is ever low while memRasN is high.
- R4: After an access, memRasN stays high for at least 5 cycles before it falls again, so one random cycle takes at least 11 cycles.
- R5: In a read, all four column strobes fall, memWeN stays 1 and memDqOe stays 0. memDqIn is sampled in the last cycle that memRasN is low. rdData shows that value with rdValid high for exactly one cycle, the first cycle in which memRasN is high again.
- R6: In a write, memWeN is 0, memDqOe is 1 and memDqOut equals the request's write data for every cycle that memRasN is low. This includes the cycles before the column strobes fall. memCasN[i] goes low only when reqBe[i] is 1, and reqBe[i] covers data bits [8i+7:8i].
- R7: reqReady is high only while the controller is idle and no refresh is requested or granted. Each cycle with reqValid and reqReady both high starts exactly one access.
- R8: refGrant rises only from idle, after precharge has finished. It stays high while refReq is high. While it is high, memRasN is 1, memCasN is 4'hF and reqReady is 0. A refresh request wins over a host request in the same cycle.
- R9: A write with reqBe equal to 4'b0000 drives no column strobe low and leaves memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 24 | Word address, row in [23:12], column in [11:0] |
| reqWdata | input | 32 | Write data |
| reqBe | input | 4 | Byte enables, bit i for bits [8i+7:8i] |
| rdValid | output | 1 | One-cycle pulse marking rdData valid |
| rdData | output | 32 | Read data |
| refReq | input | 1 | Refresh request from the scheduler |
| refGrant | output | 1 | Refresh grant, memory bus released |
| memAddr | output | 12 | Multiplexed row/column address |
| memRasN | output | 1 | Active-low row strobe |
| memCasN | output | 4 | Active-low column strobes, one per byte lane |
| memWeN | output | 1 | Active-low write enable |
| memDqOut | output | 32 | Data driven to memory |
| memDqOe | output | 1 | Output enable for memDqOut |
| memDqIn | input | 32 | Data returned by memory |

## Verification
The bench targets the byte-lane mapping and the empty-mask write. A swapped lane or a strobe that fires on a zero mask would corrupt bytes that a later read-back exposes. It measures row-active width, the row-to-column delay and the precharge gap cycle by cycle; a miscounted phase counter shows up as a 5- or 7-cycle strobe or a short precharge. It also asserts a refresh request in the middle of an access and together with a host request. A controller that granted too early would grant while the row strobe is low, and one with the wrong priority would start a row cycle during the grant.

// File: rtl/edoPkg.sv
package edoPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE,
    ST_REF
  } edoState_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic latch;    // capture host request
    logic rasOn;    // row strobe active
    logic colSel;   // column address on the pins
    logic casOn;    // column strobe phase
    logic wrDrive;  // write enable and data drivers on
    logic sample;   // capture read data this cycle
  } edoStrobe_t;

endpackage

// File: rtl/edoCtrlFsm.sv
module edoCtrlFsm
  import edoPkg::*;
#(
  parameter int RAS_CYC = 6,
  parameter int RP_CYC  = 4,
  parameter int RCD_CYC = 2,
  parameter int RC_CYC  = 11,
  parameter int AA_CYC  = 3,
  parameter int CAC_CYC = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  input  logic       refReq,
  output logic       refGrant,
  output edoStrobe_t strb
);

  localparam int RAS_REST = RAS_CYC - RCD_CYC;
  localparam int COL_A    = (RAS_REST > AA_CYC) ? RAS_REST : AA_CYC;
  localparam int COL_CYC  = (COL_A > CAC_CYC) ? COL_A : CAC_CYC;
  localparam int RC_REST  = RC_CYC - RCD_CYC - COL_CYC;
  localparam int PRE_CYC  = (RC_REST > RP_CYC) ? RC_REST : RP_CYC;
  localparam int MAX_AB   = (RCD_CYC > COL_CYC) ? RCD_CYC : COL_CYC;
  localparam int CNT_MAX  = (MAX_AB > PRE_CYC) ? MAX_AB : PRE_CYC;
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  edoState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             opWr;
  logic             cntDone;

  assign cntDone = (cnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      opWr  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (refReq) begin
            state <= ST_REF;
          end else if (reqValid) begin
            state <= ST_ROW;
            cnt   <= CNT_W'(RCD_CYC - 1);
            opWr  <= reqWrite;
          end
        end
        ST_ROW: begin
          if (cntDone) begin
            state <= ST_COL;
            cnt   <= CNT_W'(COL_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_COL: begin
          if (cntDone) begin
            state <= ST_PRE;
            cnt   <= CNT_W'(PRE_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PRE: begin
          if (cntDone) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_REF: begin
          if (!refReq) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE) && !refReq;
  assign refGrant = (state == ST_REF);

  always_comb begin
    strb         = '0;
    strb.latch   = (state == ST_IDLE) && reqValid && !refReq;
    strb.rasOn   = (state == ST_ROW) || (state == ST_COL);
    strb.colSel  = (state == ST_COL) || (state == ST_PRE);
    strb.casOn   = (state == ST_COL);
    strb.wrDrive = opWr && ((state == ST_ROW) || (state == ST_COL));
    strb.sample  = (state == ST_COL) && cntDone && !opWr;
  end

  // R8: a grant only ever starts from idle
  p_grant_from_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refGrant) |-> ($past(state) == ST_IDLE));

  // R8: host is held off while granted
  p_ready_blocked_r8: assert property (@(posedge clk) disable iff (!rstN)
    refGrant |-> !reqReady);

endmodule

// File: rtl/edoDatapath.sv
module edoDatapath
  import edoPkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  edoStrobe_t               strb,
  input  logic                     reqWrite,
  input  logic [ROW_W+COL_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W/8-1:0]      reqBe,
  output logic                     rdValid,
  output logic [DATA_W-1:0]        rdData,
  output logic [ROW_W-1:0]         memAddr,
  output logic                     memRasN,
  output logic [DATA_W/8-1:0]      memCasN,
  output logic                     memWeN,
  output logic [DATA_W-1:0]        memDqOut,
  output logic                     memDqOe,
  input  logic [DATA_W-1:0]        memDqIn
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int LANES  = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;
  logic              wrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      wrQ    <= 1'b0;
    end else if (strb.latch) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqBe;
      wrQ    <= reqWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strb.sample;
      if (strb.sample) rdData <= memDqIn;
    end
  end

  assign memRasN  = !strb.rasOn;
  assign memAddr  = strb.colSel ? ROW_W'(addrQ[COL_W-1:0]) : addrQ[ADDR_W-1:COL_W];
  assign memWeN   = !strb.wrDrive;
  assign memDqOe  = strb.wrDrive;
  assign memDqOut = wdataQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign memCasN[g] = !(strb.casOn && (!wrQ || beQ[g]));
  end

  // R3: column strobes only inside an active row
  p_cas_in_ras_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memCasN != '1) |-> !memRasN);

  // R6: data drivers only with write enable low
  p_oe_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> !memWeN);

  // R6: write enable settled before column strobes fall (early write)
  p_early_we_r6: assert property (@(posedge clk) disable iff (!rstN)
    (($past(memCasN) == '1) && (memCasN != '1)) |-> $stable(memWeN));

endmodule

// File: rtl/edoAccessCtrl.sv
module edoAccessCtrl
  import edoPkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 12,
  parameter int DATA_W  = 32,
  parameter int RAS_CYC = 6,
  parameter int RP_CYC  = 4,
  parameter int RCD_CYC = 2,
  parameter int RC_CYC  = 11,
  parameter int AA_CYC  = 3,
  parameter int CAC_CYC = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  input  logic [DATA_W/8-1:0]    reqBe,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData,
  input  logic                   refReq,
  output logic                   refGrant,
  output logic [ROW_W-1:0]       memAddr,
  output logic                   memRasN,
  output logic [DATA_W/8-1:0]    memCasN,
  output logic                   memWeN,
  output logic [DATA_W-1:0]      memDqOut,
  output logic                   memDqOe,
  input  logic [DATA_W-1:0]      memDqIn
);

  localparam int RAS_REST = RAS_CYC - RCD_CYC;
  localparam int COL_A    = (RAS_REST > AA_CYC) ? RAS_REST : AA_CYC;
  localparam int COL_CYC  = (COL_A > CAC_CYC) ? COL_A : CAC_CYC;
  localparam int RC_REST  = RC_CYC - RCD_CYC - COL_CYC;
  localparam int PRE_CYC  = (RC_REST > RP_CYC) ? RC_REST : RP_CYC;
  localparam int HI_W     = $clog2(PRE_CYC + 1);

  edoStrobe_t strb;

  edoCtrlFsm #(
    .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC), .RCD_CYC(RCD_CYC),
    .RC_CYC(RC_CYC), .AA_CYC(AA_CYC), .CAC_CYC(CAC_CYC)
  ) i_fsm (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqReady(reqReady),
    .refReq(refReq), .refGrant(refGrant), .strb(strb)
  );

  edoDatapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rdValid(rdValid), .rdData(rdData),
    .memAddr(memAddr), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // Checker state: cycles the row strobe has been high, saturating
  logic [HI_W-1:0] hiCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                  hiCnt <= HI_W'(PRE_CYC);
    else if (!memRasN)                          hiCnt <= '0;
    else if (hiCnt != HI_W'(PRE_CYC))           hiCnt <= hiCnt + 1'b1;
  end

  // R4: precharge respected before every row strobe
  p_precharge_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memRasN) |-> (hiCnt == HI_W'(PRE_CYC)));

  // R5: read data appears as the row strobe rises
  p_rdvalid_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $rose(memRasN));

  // R8: memory bus quiet during a grant
  p_grant_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    refGrant |-> (memRasN && (memCasN == '1)));

endmodule

// File: tb/test_edoAccessCtrl.sv
`timescale 1ns/1ps
module test_edoAccessCtrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [23:0] reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqBe = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic        refReq = 1'b0;
  logic        refGrant;
  logic [11:0] memAddr;
  logic        memRasN;
  logic [3:0]  memCasN;
  logic        memWeN;
  logic [31:0] memDqOut;
  logic        memDqOe;
  logic [31:0] memDqIn = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  edoAccessCtrl i_edoAccessCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqBe(reqBe),
    .rdValid(rdValid), .rdData(rdData), .refReq(refReq), .refGrant(refGrant),
    .memAddr(memAddr), .memRasN(memRasN), .memCasN(memCasN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory array model and shadow for expected values
  logic [31:0] memModel [logic [23:0]];
  logic [31:0] shadow   [logic [23:0]];
  logic [11:0] rowL;
  logic [3:0]  casPrev = 4'hF;

  always @(negedge memRasN) rowL = memAddr;

  always @(memCasN) begin
    if (casPrev == 4'hF && memCasN != 4'hF) begin
      logic [23:0] key;
      logic [31:0] word;
      key  = {rowL, memAddr};
      word = memModel.exists(key) ? memModel[key] : 32'h0;
      if (!memWeN) begin
        for (int i = 0; i < 4; i++)
          if (!memCasN[i]) word[8*i +: 8] = memDqOut[8*i +: 8];
        memModel[key] = word;
      end else begin
        memDqIn = word;
      end
    end
    casPrev = memCasN;
  end

  // Current access as seen by the driver
  logic [23:0] curAddr;
  logic        curWr;
  logic [31:0] curData;
  logic [3:0]  curBe;
  logic [31:0] expQ [$];

  task automatic issue(input bit wr, input logic [23:0] a,
                       input logic [31:0] d, input logic [3:0] be);
    forever begin
      @(negedge clk);
      if (reqReady && !refReq) begin
        curAddr = a; curWr = wr; curData = d; curBe = be;
        reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqBe = be;
        if (wr) begin
          logic [31:0] w;
          w = shadow.exists(a) ? shadow[a] : 32'h0;
          for (int i = 0; i < 4; i++) if (be[i]) w[8*i +: 8] = d[8*i +: 8];
          shadow[a] = w;
        end else begin
          expQ.push_back(shadow.exists(a) ? shadow[a] : 32'h0);
        end
        @(posedge clk);
        @(negedge clk);
        reqValid = 1'b0;
        break;
      end
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5", "unexpected rdValid", 1, 0);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(rdData == e, "R5", "read data", rdData, e);
      end
    end
  end

  // Strobe timing monitor
  int  rasLow = 0;
  int  rasHigh = 100;
  bit  casFired = 0;
  logic prevRasN = 1'b1;
  logic [3:0] prevCas = 4'hF;
  bit  refMid = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!memRasN) begin
        if (prevRasN) begin
          check(rasHigh >= 5, "R4", "precharge cycles", rasHigh, 5);
          check(memAddr == curAddr[23:12], "R2", "row address", memAddr, curAddr[23:12]);
          rasHigh = 0;
          casFired = 0;
        end
        rasLow++;
        if (curWr) begin
          check(!memWeN && memDqOe, "R6", "we/oe during row", {memWeN, memDqOe}, 2'b01);
          check(memDqOut == curData, "R6", "write data", memDqOut, curData);
        end else begin
          check(memWeN && !memDqOe, "R5", "we/oe on read", {memWeN, memDqOe}, 2'b10);
        end
        if (memCasN != 4'hF) begin
          casFired = 1;
          check(memAddr == curAddr[11:0], "R2", "column address", memAddr, curAddr[11:0]);
          if (prevCas == 4'hF) begin
            check(rasLow == 3, "R3", "row-to-column delay", rasLow, 3);
            if (curWr)
              check(memCasN == ~curBe, "R6", "lane strobes", memCasN, ~curBe);
            else
              check(memCasN == 4'h0, "R5", "read lane strobes", memCasN, 0);
          end
        end
        check(!refGrant, "R8", "no grant during row", refGrant, 0);
      end else begin
        if (!prevRasN) begin
          check(rasLow == 6, "R3", "row strobe width", rasLow, 6);
          if (curWr && curBe == 4'h0)
            check(!casFired, "R9", "no strobe on empty mask", casFired, 0);
          rasLow = 0;
        end
        check(memCasN == 4'hF, "R3", "cas high outside row", memCasN, 4'hF);
        if (refGrant && refMid) begin
          check(rasHigh >= 5, "R8", "grant after precharge", rasHigh, 5);
          refMid = 0;
        end
        rasHigh++;
      end
      prevRasN = memRasN;
      prevCas  = memCasN;
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    curAddr = '0; curWr = 0; curData = '0; curBe = '0;
    repeat (3) @(negedge clk);
    // R1: reset values while reset held
    check(memRasN && memCasN == 4'hF && memWeN && !memDqOe, "R1", "mem pins in reset",
          {memRasN, memCasN, memWeN, memDqOe}, 7'b1111110);
    check(!rdValid && !refGrant && reqReady, "R1", "host pins in reset",
          {rdValid, refGrant, reqReady}, 3'b001);
    rstN = 1'b1;
    @(negedge clk);
    check(memRasN && memCasN == 4'hF && reqReady, "R1", "after reset",
          {memRasN, memCasN, reqReady}, 6'b111111);

    // Main traffic: full writes then reads
    issue(1, 24'h123456, 32'hDEADBEEF, 4'hF);
    issue(1, 24'hFFF000, 32'h01234567, 4'hF);
    issue(1, 24'h000FFF, 32'hA5A55A5A, 4'hF);
    issue(0, 24'h123456, '0, 4'hF);
    issue(0, 24'hFFF000, '0, 4'hF);
    issue(0, 24'h000FFF, '0, 4'hF);
    issue(0, 24'h777777, '0, 4'hF);

    // R6: byte lanes, one at a time and mixed
    issue(1, 24'h123456, 32'h11223344, 4'b0001);
    issue(1, 24'hFFF000, 32'hCAFEF00D, 4'b1010);
    issue(1, 24'h000FFF, 32'h99887766, 4'b0100);
    issue(0, 24'h123456, '0, 4'hF);
    issue(0, 24'hFFF000, '0, 4'hF);
    issue(0, 24'h000FFF, '0, 4'hF);

    // R9: empty mask write leaves data intact
    issue(1, 24'h123456, 32'h00000000, 4'b0000);
    issue(0, 24'h123456, '0, 4'hF);

    // R7/R8: grant from idle, host blocked
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    refReq = 1'b1;
    @(negedge clk);
    check(refGrant == 1'b1, "R8", "grant from idle", refGrant, 1);
    check(reqReady == 1'b0, "R7", "ready low under grant", reqReady, 0);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 24'h123456; reqWdata = 32'hBAD0BAD0; reqBe = 4'hF;
    repeat (4) begin
      @(negedge clk);
      check(memRasN && refGrant, "R8", "no access while granted", {memRasN, refGrant}, 2'b11);
    end
    reqValid = 1'b0;
    refReq = 1'b0;
    @(negedge clk);
    check(!refGrant, "R8", "grant released", refGrant, 0);
    check(reqReady, "R7", "ready after release", reqReady, 1);

    // R8: refresh and host request in the same cycle, refresh wins
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 24'h000FFF; reqBe = 4'hF;
    refReq = 1'b1;
    @(negedge clk);
    check(refGrant && memRasN, "R8", "refresh priority", {refGrant, memRasN}, 2'b11);
    reqValid = 1'b0;
    refReq = 1'b0;
    @(negedge clk);

    // R8: refresh requested mid-access waits for precharge
    issue(0, 24'hFFF000, '0, 4'hF);
    refMid = 1;
    refReq = 1'b1;
    while (!refGrant) @(negedge clk);
    @(negedge clk);
    refReq = 1'b0;
    @(negedge clk);
    check(!refMid, "R8", "mid-access grant checked", refMid, 0);

    // Back-to-back reads after refresh
    issue(0, 24'h000FFF, '0, 4'hF);
    issue(0, 24'h777777, '0, 4'hF);

    while (expQ.size() != 0) @(negedge clk);
    repeat (12) @(negedge clk);
    summary();
    $finish;
  end

endmodule